// File: doc/BRIEF.md
# Host-side bridge to a byte-wide parallel FIFO device

This block lives in an FPGA and talks to an external byte-wide FIFO device over one shared 8-bit bus that carries data in both directions. The device reports two active-low status flags: one says a received byte is waiting, the other says there is room to accept a byte. The bridge turns these into two ordinary internal streams. Bytes read from the device appear on a receive stream with valid/ready handshaking. Bytes offered on a transmit stream with valid/ready handshaking are written out to the device.

Reads use an active-low strobe. The device puts its byte on the bus while that strobe is low, and each pulse consumes one byte. Writes use an active-high strobe, and the device takes the byte when that strobe falls. The bridge drives the bus only while a write is in progress. It passes both status flags through two-flop synchronizers and waits a settle period after every strobe, so each decision uses the flag state that follows the previous transfer. Reads have priority. After each read, one waiting write gets a turn. Parameters set the strobe width, the write data setup time and the settle/turnaround time.

Top module: `hostFifoBridge`

## Requirements
- R1: During and straight after reset, `extRdN` is 1, `extWr` is 0, `busOe` is 0 and `rxValid` is 0.
- R2: A read pulse holds `extRdN` low for exactly STROBE_CLKS clocks. It starts only when the synchronized data-available flag (`extDataWaitN` = 0 means a byte is waiting) is low. Each pulse takes exactly one byte from the device.
- R3: The byte on `busIn` during the last low clock of the read pulse appears on `rxData` with `rxValid` = 1. Both stay unchanged until `rxReady` is 1, and no further read pulse starts while that byte is held.
- R4: A write pulse holds `extWr` high for exactly STROBE_CLKS clocks. It starts only when `txValid` is 1 and the synchronized space flag (`extRoomN` = 0 means room) is low. Bytes leave in the order the transmit stream accepted them.
- R5: `busOe` is 1 only during a write. `busOut` holds the accepted byte with `busOe` = 1 for at least SETUP_CLKS clocks before `extWr` rises, and stays unchanged through the clock after `extWr` falls.
- R6: `busOe` is 0 in the clock before a read pulse starts and throughout that pulse.
- R7: When a read and a write are both possible, the read goes first. After each completed read, a waiting write goes next, so that with both directions busy the strobes alternate read, write, read, write.
- R8: If a status flag goes inactive within one clock after a strobe ends, no further strobe of that kind is issued until the flag becomes active again.
- R9: `extRdN` low and `extWr` high never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extDataWaitN | input | 1 | Device flag, low when a received byte is waiting |
| extRoomN | input | 1 | Device flag, low when the device can accept a byte |
| extRdN | output | 1 | Active-low read strobe |
| extWr | output | 1 | Active-high write strobe, byte taken on its falling edge |
| busIn | input | 8 | Data from the shared bus |
| busOut | output | 8 | Data driven onto the shared bus |
| busOe | output | 1 | Output enable for the bus drivers |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Received byte is valid |
| rxReady | input | 1 | Consumer accepts the received byte |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit byte is offered |
| txReady | output | 1 | Bridge accepts the transmit byte this clock |

## Verification
A control state that goes wrong shows up at the device pins within one strobe. A pulse that is too long or too short, or a read that overlaps a driven bus, can be seen in the same clock it happens. A settle count that is too short lets a strobe go out against a flag that has just become inactive, and the device model reports it as a read from an empty device or a write into a full one. A wrong arbitration bit changes the order of the strobes from the second transfer on. A fault in capture or hold timing changes the bytes the scoreboard sees on either stream.

// File: rtl/hfb_pkg.sv
package hfb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LOW,
    ST_RD_WAIT,
    ST_WR_SETUP,
    ST_WR_HIGH,
    ST_WR_HOLD,
    ST_SETTLE
  } hfbState_t;

  typedef struct packed {
    logic loadTx;
    logic captureRx;
    logic driveBus;
  } hfbStrobes_t;

endpackage

// File: rtl/hfbData.sv
module hfbData #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  hfb_pkg::hfbStrobes_t strobes,
  input  logic                extDataWaitN,
  input  logic                extRoomN,
  output logic                dataWaitSync,
  output logic                roomSync,
  input  logic [DATA_W-1:0]   busIn,
  output logic [DATA_W-1:0]   busOut,
  output logic                busOe,
  input  logic [DATA_W-1:0]   txData,
  output logic [DATA_W-1:0]   rxData,
  output logic                rxValid,
  input  logic                rxReady
);

  logic [1:0] waitPipe;
  logic [1:0] roomPipe;
  logic [DATA_W-1:0] txHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitPipe <= 2'b11;
      roomPipe <= 2'b11;
    end else begin
      waitPipe <= {waitPipe[0], extDataWaitN};
      roomPipe <= {roomPipe[0], extRoomN};
    end
  end

  assign dataWaitSync = waitPipe[1];
  assign roomSync     = roomPipe[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= '0;
    end else if (strobes.loadTx) begin
      txHold <= txData;
    end
  end

  assign busOut = txHold;
  assign busOe  = strobes.driveBus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else if (strobes.captureRx) begin
      rxData  <= busIn;
      rxValid <= 1'b1;
    end else if (rxValid && rxReady) begin
      rxValid <= 1'b0;
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData))); // R3

  AST_NO_CAPTURE_OVER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |-> !strobes.captureRx); // R3

endmodule

// File: rtl/hfbCtrl.sv
module hfbCtrl #(
  parameter int SETUP_CLKS  = 2,
  parameter int STROBE_CLKS = 3,
  parameter int TURN_CLKS   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dataWaitSync,
  input  logic                 roomSync,
  input  logic                 txValid,
  input  logic                 rxReady,
  output logic                 txReady,
  output logic                 extRdN,
  output logic                 extWr,
  output hfb_pkg::hfbStrobes_t strobes
);
  import hfb_pkg::*;

  localparam int MAX_A = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS;
  localparam int MAX_C = (MAX_A > TURN_CLKS) ? MAX_A : TURN_CLKS;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CLKS - 1);
  localparam logic [CNT_W-1:0] TURN_LAST   = CNT_W'(TURN_CLKS - 1);

  hfbState_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic writeTurn;
  logic canRd, canWr, startWr, startRd;

  assign canRd   = !dataWaitSync;
  assign canWr   = !roomSync && txValid;
  assign startWr = (state == ST_IDLE) && canWr && (writeTurn || !canRd);
  assign startRd = (state == ST_IDLE) && canRd && !startWr;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (startWr) nextState = ST_WR_SETUP;
                   else if (startRd) nextState = ST_RD_LOW;
      ST_RD_LOW:   if (cnt == STROBE_LAST) nextState = ST_RD_WAIT;
      ST_RD_WAIT:  if (rxReady) nextState = ST_SETTLE;
      ST_WR_SETUP: if (cnt == SETUP_LAST) nextState = ST_WR_HIGH;
      ST_WR_HIGH:  if (cnt == STROBE_LAST) nextState = ST_WR_HOLD;
      ST_WR_HOLD:  nextState = ST_SETTLE;
      ST_SETTLE:   if (cnt == TURN_LAST) nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      writeTurn <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= (nextState != state) ? '0 : cnt + 1'b1;
      if (state == ST_RD_WAIT && rxReady) writeTurn <= 1'b1;
      else if (startWr || startRd)        writeTurn <= 1'b0;
    end
  end

  assign txReady           = startWr;
  assign extRdN            = (state != ST_RD_LOW);
  assign extWr             = (state == ST_WR_HIGH);
  assign strobes.loadTx    = startWr;
  assign strobes.captureRx = (state == ST_RD_LOW) && (cnt == STROBE_LAST);
  assign strobes.driveBus  = (state == ST_WR_SETUP) || (state == ST_WR_HIGH) ||
                             (state == ST_WR_HOLD);

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!extRdN && extWr)); // R9

  AST_RD_ON_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extRdN) |-> $past(!dataWaitSync)); // R2

  AST_WR_ON_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (!roomSync && txValid)); // R4

endmodule

// File: rtl/hostFifoBridge.sv
module hostFifoBridge #(
  parameter int DATA_W      = 8,
  parameter int SETUP_CLKS  = 2,
  parameter int STROBE_CLKS = 3,
  parameter int TURN_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extDataWaitN,
  input  logic              extRoomN,
  output logic              extRdN,
  output logic              extWr,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);

  hfb_pkg::hfbStrobes_t strobes;
  logic dataWaitSync, roomSync;

  hfbCtrl #(
    .SETUP_CLKS(SETUP_CLKS), .STROBE_CLKS(STROBE_CLKS), .TURN_CLKS(TURN_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .dataWaitSync(dataWaitSync), .roomSync(roomSync),
    .txValid(txValid), .rxReady(rxReady), .txReady(txReady),
    .extRdN(extRdN), .extWr(extWr), .strobes(strobes)
  );

  hfbData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .extDataWaitN(extDataWaitN), .extRoomN(extRoomN),
    .dataWaitSync(dataWaitSync), .roomSync(roomSync),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .txData(txData), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady)
  );

  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    extWr |-> busOe); // R5

  AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (extWr || $fell(extWr)) |-> (busOe && $stable(busOut))); // R5

  AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extRdN) |-> (!busOe && !$past(busOe))); // R6

endmodule

// File: tb/hostFifoBridge_bench.sv
module hostFifoBridge_bench;
  localparam int STROBE = 3;
  localparam int SETUP  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extDataWaitN = 1'b1, extRoomN = 1'b0;
  logic extRdN, extWr, busOe, rxValid, txReady;
  logic rxReady = 1'b0, txValid = 1'b0;
  logic [7:0] busIn, busOut, rxData, txData = 8'h00;

  always #5 clk = ~clk;

  hostFifoBridge u_hostFifoBridge (
    .clk(clk), .rstN(rstN), .extDataWaitN(extDataWaitN), .extRoomN(extRoomN),
    .extRdN(extRdN), .extWr(extWr), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady)
  );

  int checks = 0, errors = 0;
  logic [7:0] devQ[$];
  logic [7:0] expRx[$];
  logic [7:0] expTx[$];
  logic [7:0] ordQ[$];
  logic [7:0] devHead = 8'hEE;
  int txCount = 0, txCap = 1000;
  int rdPulses = 0, wrPulses = 0;

  assign busIn = extRdN ? 8'hEE : devHead;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadDev(input logic [7:0] b);
    devQ.push_back(b);
    expRx.push_back(b);
    devHead = devQ[0];
    extDataWaitN = 1'b0;
  endtask

  task automatic sendTx(input logic [7:0] b);
    @(negedge clk);
    txValid = 1'b1;
    txData = b;
    #1;
    while (!txReady) begin
      @(negedge clk);
      #1;
    end
    expTx.push_back(b);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  // device model and monitor, sampled away from the active edge
  logic prevRdN = 1'b1, prevWr = 1'b0, prevOe = 1'b0;
  int rdLow = 0, wrHigh = 0, oeRun = 0;
  logic [7:0] wrByte = 8'h00, heldData = 8'h00;
  logic heldPrev = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      oeRun = busOe ? oeRun + 1 : 0;
      if (!extRdN) rdLow++;
      if (extWr) wrHigh++;
      if (!extRdN && prevRdN) begin
        rdPulses++;
        ordQ.push_back(8'h52);
        check(devQ.size() > 0, "R2 read from empty device", devQ.size(), 1);
        check(!busOe && !prevOe, "R6 bus released before read", {prevOe, busOe}, 0);
      end
      if (!extRdN) check(!busOe, "R6 bus undriven during read", busOe, 0);
      check(!(!extRdN && extWr), "R9 both strobes", {extRdN, extWr}, 2'b11);
      if (extRdN && !prevRdN) begin
        check(rdLow == STROBE, "R2 read strobe width", rdLow, STROBE);
        rdLow = 0;
        if (devQ.size() > 0) void'(devQ.pop_front());
        devHead = (devQ.size() > 0) ? devQ[0] : 8'hEE;
        extDataWaitN = (devQ.size() == 0);
      end
      if (extWr && !prevWr) begin
        wrPulses++;
        ordQ.push_back(8'h57);
        wrByte = busOut;
        check(oeRun >= SETUP + 1, "R5 write setup", oeRun, SETUP + 1);
        check(txCount < txCap, "R4 write into full device", txCount, txCap);
      end
      if (!extWr && prevWr) begin
        check(wrHigh == STROBE, "R4 write strobe width", wrHigh, STROBE);
        wrHigh = 0;
        check(busOe && busOut == wrByte, "R5 write hold", busOut, wrByte);
        if (expTx.size() > 0) begin
          logic [7:0] e;
          e = expTx.pop_front();
          check(busOut == e, "R4 tx byte", busOut, e);
        end else check(1'b0, "R4 unexpected write", busOut, 0);
        txCount++;
        extRoomN = (txCount >= txCap);
      end
      if (rxValid && rxReady) begin
        if (expRx.size() > 0) begin
          logic [7:0] e;
          e = expRx.pop_front();
          check(rxData == e, "R3 rx byte", rxData, e);
        end else check(1'b0, "R3 unexpected rx", rxData, 0);
      end
      if (heldPrev && rxValid)
        check(rxData == heldData, "R3 rx held stable", rxData, heldData);
      heldPrev = rxValid && !rxReady;
      heldData = rxData;
    end
    prevRdN = extRdN;
    prevWr  = extWr;
    prevOe  = busOe;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(extRdN == 1'b1, "R1 reset read strobe", extRdN, 1);
    check(extWr == 1'b0, "R1 reset write strobe", extWr, 0);
    check(busOe == 1'b0, "R1 reset bus", busOe, 0);
    check(rxValid == 1'b0, "R1 reset rx valid", rxValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(extRdN && !extWr && !busOe, "R1 after reset", {extRdN, extWr, busOe}, 3'b100);

    // empty device: no read strobes (R8 empty case)
    repeat (40) @(negedge clk);
    check(rdPulses == 0, "R2 no read while empty", rdPulses, 0);

    // alternation with both sides busy (R7)
    rxReady = 1'b1;
    loadDev(8'h11); loadDev(8'h22); loadDev(8'h33);
    repeat (4) @(negedge clk);
    fork
      begin sendTx(8'hA1); sendTx(8'hB2); sendTx(8'hC3); end
    join_none
    repeat (400) @(negedge clk);
    check(ordQ.size() == 6, "R7 strobe count", ordQ.size(), 6);
    for (int i = 0; i < 6 && i < ordQ.size(); i++)
      check(ordQ[i] == ((i % 2 == 0) ? 8'h52 : 8'h57), "R7 order", ordQ[i],
            (i % 2 == 0) ? 8'h52 : 8'h57);
    check(expRx.size() == 0 && expTx.size() == 0, "R3 R4 drained",
          expRx.size() + expTx.size(), 0);

    // receive backpressure (R3)
    rxReady = 1'b0;
    loadDev(8'h5A); loadDev(8'hC7);
    repeat (60) @(negedge clk);
    check(rdPulses == 4, "R3 one read while held", rdPulses, 4);
    check(rxValid && rxData == 8'h5A, "R3 held byte", rxData, 8'h5A);
    rxReady = 1'b1;
    repeat (60) @(negedge clk);
    check(rdPulses == 5 && expRx.size() == 0, "R3 drained after ready", rdPulses, 5);

    // device fills after two writes (R8)
    txCap = txCount + 2;
    fork
      begin sendTx(8'h01); sendTx(8'h02); sendTx(8'h03); sendTx(8'h04); end
    join_none
    repeat (150) @(negedge clk);
    check(wrPulses == 5, "R8 stop at full", wrPulses, 5);
    check(extRoomN == 1'b1, "R8 device full", extRoomN, 1);
    txCap = 1000;
    extRoomN = 1'b0;
    repeat (150) @(negedge clk);
    check(wrPulses == 7 && expTx.size() == 0, "R4 resume after room", wrPulses, 7);

    // write only, with different data patterns (R4 R5)
    fork
      begin sendTx(8'hFF); sendTx(8'h00); sendTx(8'h80); end
    join_none
    repeat (200) @(negedge clk);
    check(wrPulses == 10 && expTx.size() == 0, "R4 pattern writes", wrPulses, 10);
    check(!busOe, "R5 bus released when idle", busOe, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule